// File: doc/BRIEF.md
# Three-State Snooping Coherence Line Controller

This block keeps the coherence state of every line of one write-back cache that sits on a shared, atomic snooping bus. Each line is Invalid, Shared or Modified. The block takes two kinds of input. The processor side sends load, store and evict events, one at a time, each with a line index. The snoop side reports transactions that other caches put on the bus. From these inputs the block updates the state table, raises its own bus requests (read, read-for-ownership, writeback) and flags the cycles in which it must supply dirty data to another requester.

A processor event that needs the bus is held in a pending register. The block holds the request on its bus outputs until the bus grants and completes it with an acknowledge. Only then does the line take its new state and the processor see completion. Snoops are applied in every cycle, including while a request is pending. The snoop port has its own read of the state table, so snoop lookups never compete with processor lookups. When both sides name the same line in the same cycle, the snoop is applied first and the processor event is decided on the state the snoop leaves behind.

Top module: `msi_coh_ctrl`

## Requirements
- R1: After reset every line reads Invalid, and busReq, procDone and supplyData are low. Line states are encoded Invalid=0, Shared=1, Modified=2.
- R2: A load (procOp=0) to an Invalid line raises busReq with busCmd=1 (read) and the line index. The line becomes Shared once busAck completes the request.
- R3: A store (procOp=1) to an Invalid or Shared line raises busReq with busCmd=2 (read-for-ownership). The line becomes Modified only after busAck.
- R4: Loads to Shared or Modified lines and stores to Modified lines raise no bus request, leave the state unchanged, and give procDone in the cycle after the event is taken.
- R5: A Modified line that observes a snoop read (snoopCmd=1) becomes Shared and pulses supplyData with its index in the next cycle. A Modified line that observes snoopCmd=2 becomes Invalid with the same pulse.
- R6: A Shared line that observes snoopCmd=2 becomes Invalid with no supplyData. A Shared line that observes snoopCmd=1 stays Shared with no supplyData.
- R7: An evict (procOp=2) of a Modified line raises busCmd=3 (writeback) and the line is Invalid after busAck. Evicting a Shared or Invalid line makes it Invalid with no bus request.
- R8: An observed writeback (snoopCmd=3) changes no line and gives no supplyData. No snoop command changes an Invalid line.
- R9: busReq, busCmd and busIndex hold steady until the cycle busAck is seen high. busReq is low in the next cycle, and procDone is a single-cycle pulse in that next cycle.
- R10: When a snoop and a processor event name the same line in the same cycle, the snoop is applied first and the processor event is evaluated on the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| procValid | input | 1 | Processor event present; held until procDone |
| procOp | input | 2 | 0 load, 1 store, 2 evict |
| procIndex | input | IDX_W | Line addressed by the processor; also selects procState |
| procDone | output | 1 | One-cycle completion pulse for the processor event |
| procState | output | 2 | Current state of the line at procIndex |
| snoopValid | input | 1 | A transaction from another cache is on the bus |
| snoopCmd | input | 2 | 1 read, 2 read-for-ownership, 3 writeback |
| snoopIndex | input | IDX_W | Line addressed by the observed transaction |
| supplyData | output | 1 | This cache supplies dirty data for the observed request |
| supplyIndex | output | IDX_W | Line being supplied |
| busReq | output | 1 | Own bus request pending |
| busCmd | output | 2 | Own request: 1 read, 2 read-for-ownership, 3 writeback |
| busIndex | output | IDX_W | Line of own request |
| busAck | input | 1 | Own request granted and completed |

## Verification
The processor side is swept over every pairing of starting state and event. Each case shows whether the block told apart hits that need no bus, misses and upgrades that need ownership, and dirty evictions that must write back. The snoop side is swept over every pairing of starting state and observed command, which separates a dirty-data supply from a silent invalidation and from an ignored writeback. A third sweep puts a snoop and a processor event on the same line in the same cycle, for every combination. It shows whether the processor decision follows the state the snoop produced rather than the old one. Each request is held unacknowledged for several cycles to confirm that the bus outputs stay steady.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_M = 2'd2
  } lineState_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RDX  = 2'd2,
    CMD_WB   = 2'd3
  } busCmd_t;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_EVICT = 2'd2,
    OP_NOP   = 2'd3
  } procOp_t;

  typedef struct packed {
    logic capture;    // latch a bus-bound processor event
    logic commitNow;  // apply a processor event that needs no bus
    logic commitAck;  // apply the pending event on bus completion
  } ctrlStrobe_t;

  // State after observing another cache's transaction
  function automatic lineState_t snoopNext(lineState_t st, busCmd_t cmd);
    lineState_t r;
    r = st;
    case (cmd)
      CMD_RD:  if (st == LINE_M) r = LINE_S;
      CMD_RDX: r = LINE_I;
      default: r = st;
    endcase
    return r;
  endfunction

  function automatic logic snoopSupplies(lineState_t st, busCmd_t cmd);
    return (st == LINE_M) && (cmd == CMD_RD || cmd == CMD_RDX);
  endfunction

  function automatic busCmd_t procBus(lineState_t st, procOp_t op);
    busCmd_t r;
    r = CMD_NONE;
    case (op)
      OP_LOAD:  if (st == LINE_I) r = CMD_RD;
      OP_STORE: if (st != LINE_M) r = CMD_RDX;
      OP_EVICT: if (st == LINE_M) r = CMD_WB;
      default:  r = CMD_NONE;
    endcase
    return r;
  endfunction

  function automatic lineState_t procTarget(lineState_t st, procOp_t op);
    lineState_t r;
    r = st;
    case (op)
      OP_LOAD:  if (st == LINE_I) r = LINE_S;
      OP_STORE: r = LINE_M;
      OP_EVICT: r = LINE_I;
      default:  r = st;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/msi_coh_state.sv
module msi_coh_state
  import msi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  procOp_t           procOp,
  input  logic [IDX_W-1:0]  procIndex,
  input  logic              snoopValid,
  input  busCmd_t           snoopCmd,
  input  logic [IDX_W-1:0]  snoopIndex,
  output logic              needBus,
  output lineState_t        procState,
  output logic              supplyData,
  output logic [IDX_W-1:0]  supplyIndex,
  output busCmd_t           pendCmd,
  output logic [IDX_W-1:0]  pendIndex
);

  lineState_t lineQ [NUM_LINES];
  lineState_t snoopCur, snoopNew, procEff, pendTarget, wrVal;
  logic [IDX_W-1:0] wrIdx;
  logic wrProc, sameLine;

  assign snoopCur  = lineQ[snoopIndex];
  assign snoopNew  = snoopNext(snoopCur, snoopCmd);
  assign sameLine  = snoopValid && (snoopIndex == procIndex);
  // snoop first, processor event judged on the post-snoop state
  assign procEff   = sameLine ? snoopNew : lineQ[procIndex];
  assign needBus   = (procBus(procEff, procOp) != CMD_NONE);
  assign procState = lineQ[procIndex];

  assign wrProc = strobe.commitNow | strobe.commitAck;
  assign wrIdx  = strobe.commitAck ? pendIndex : procIndex;
  assign wrVal  = strobe.commitAck ? pendTarget : procTarget(procEff, procOp);

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineQ[g] <= LINE_I;
      end else if (wrProc && wrIdx == IDX_W'(g)) begin
        lineQ[g] <= wrVal;
      end else if (snoopValid && snoopIndex == IDX_W'(g)) begin
        lineQ[g] <= snoopNew;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCmd    <= CMD_NONE;
      pendIndex  <= '0;
      pendTarget <= LINE_I;
    end else if (strobe.capture) begin
      pendCmd    <= procBus(procEff, procOp);
      pendIndex  <= procIndex;
      pendTarget <= procTarget(procEff, procOp);
    end else if (strobe.commitAck) begin
      pendCmd    <= CMD_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      supplyData  <= 1'b0;
      supplyIndex <= '0;
    end else begin
      supplyData  <= snoopValid && snoopSupplies(snoopCur, snoopCmd);
      supplyIndex <= snoopIndex;
    end
  end

  AST_SUPPLY_LEFT_M: assert property (@(posedge clk) disable iff (!rstN)
    supplyData |-> lineQ[supplyIndex] != LINE_M); // R5

  AST_RD_DEMOTES_M: assert property (@(posedge clk) disable iff (!rstN)
    snoopValid && snoopCmd == CMD_RD && !(wrProc && wrIdx == snoopIndex)
    |=> lineQ[$past(snoopIndex)] != LINE_M); // R5

  AST_RDX_INVALIDATES: assert property (@(posedge clk) disable iff (!rstN)
    snoopValid && snoopCmd == CMD_RDX && !(wrProc && wrIdx == snoopIndex)
    |=> lineQ[$past(snoopIndex)] == LINE_I); // R6

  AST_WB_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    snoopValid && snoopCmd == CMD_WB && !(wrProc && wrIdx == snoopIndex)
    |=> lineQ[$past(snoopIndex)] == $past(snoopCur)); // R8

  AST_PEND_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    pendCmd != CMD_NONE && !strobe.commitAck
    |=> $stable(pendCmd) && $stable(pendIndex)); // R9

  AST_OWN_AFTER_RDX: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitAck && pendCmd == CMD_RDX
    |=> lineQ[$past(pendIndex)] == LINE_M); // R3

endmodule

// File: rtl/msi_coh_fsm.sv
module msi_coh_fsm
  import msi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        procValid,
  input  logic        needBus,
  input  logic        busAck,
  output ctrlStrobe_t strobe,
  output logic        busReq,
  output logic        procDone
);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DONE} fsmState_t;
  fsmState_t stateQ, stateD;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (procValid) begin
        if (needBus) begin
          strobe.capture = 1'b1;
          stateD = ST_REQ;
        end else begin
          strobe.commitNow = 1'b1;
          stateD = ST_DONE;
        end
      end
      ST_REQ: if (busAck) begin
        strobe.commitAck = 1'b1;
        stateD = ST_DONE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busReq   = (stateQ == ST_REQ);
  assign procDone = (stateQ == ST_DONE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq); // R9

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busAck |=> !busReq && procDone); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    procDone |=> !procDone); // R9

  AST_REQ_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busReq, procDone})); // R9

endmodule

// File: rtl/msi_coh_ctrl.sv
module msi_coh_ctrl
  import msi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             procValid,
  input  logic [1:0]       procOp,
  input  logic [IDX_W-1:0] procIndex,
  output logic             procDone,
  output logic [1:0]       procState,
  input  logic             snoopValid,
  input  logic [1:0]       snoopCmd,
  input  logic [IDX_W-1:0] snoopIndex,
  output logic             supplyData,
  output logic [IDX_W-1:0] supplyIndex,
  output logic             busReq,
  output logic [1:0]       busCmd,
  output logic [IDX_W-1:0] busIndex,
  input  logic             busAck
);

  ctrlStrobe_t strobe;
  logic        needBus;
  lineState_t  stateRd;
  busCmd_t     pendCmd;

  msi_coh_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .procValid(procValid),
    .needBus  (needBus),
    .busAck   (busAck),
    .strobe   (strobe),
    .busReq   (busReq),
    .procDone (procDone)
  );

  msi_coh_state #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_state (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .procOp     (procOp_t'(procOp)),
    .procIndex  (procIndex),
    .snoopValid (snoopValid),
    .snoopCmd   (busCmd_t'(snoopCmd)),
    .snoopIndex (snoopIndex),
    .needBus    (needBus),
    .procState  (stateRd),
    .supplyData (supplyData),
    .supplyIndex(supplyIndex),
    .pendCmd    (pendCmd),
    .pendIndex  (busIndex)
  );

  assign procState = stateRd;
  assign busCmd    = pendCmd;

endmodule

// File: tb/msi_coh_ctrl_tb.sv
`timescale 1ns/1ps
module msi_coh_ctrl_tb;
  localparam int NL = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic procValid = 1'b0;
  logic [1:0] procOp = '0;
  logic [IW-1:0] procIndex = '0;
  logic procDone;
  logic [1:0] procState;
  logic snoopValid = 1'b0;
  logic [1:0] snoopCmd = '0;
  logic [IW-1:0] snoopIndex = '0;
  logic supplyData;
  logic [IW-1:0] supplyIndex;
  logic busReq;
  logic [1:0] busCmd;
  logic [IW-1:0] busIndex;
  logic busAck = 1'b0;

  int errors = 0;
  int checks = 0;
  int expState [NL];

  always #4 clk = ~clk;

  msi_coh_ctrl #(.NUM_LINES(NL)) u_dut (
    .clk(clk), .rstN(rstN), .procValid(procValid), .procOp(procOp),
    .procIndex(procIndex), .procDone(procDone), .procState(procState),
    .snoopValid(snoopValid), .snoopCmd(snoopCmd), .snoopIndex(snoopIndex),
    .supplyData(supplyData), .supplyIndex(supplyIndex), .busReq(busReq),
    .busCmd(busCmd), .busIndex(busIndex), .busAck(busAck)
  );

  // spec model: states I=0 S=1 M=2, cmds RD=1 RDX=2 WB=3, ops LD=0 ST=1 EV=2
  function automatic int mdlSnoop(int st, int cmd);
    if (cmd == 2) return 0;
    if (cmd == 1 && st == 2) return 1;
    return st;
  endfunction
  function automatic int mdlSupply(int st, int cmd);
    return (st == 2 && (cmd == 1 || cmd == 2)) ? 1 : 0;
  endfunction
  function automatic int mdlBus(int st, int op);
    if (op == 0) return (st == 0) ? 1 : 0;
    if (op == 1) return (st == 2) ? 0 : 2;
    if (op == 2) return (st == 2) ? 3 : 0;
    return 0;
  endfunction
  function automatic int mdlTgt(int st, int op);
    if (op == 0) return (st == 0) ? 1 : st;
    if (op == 1) return 2;
    if (op == 2) return 0;
    return st;
  endfunction
  function automatic string procTag(int st, int op);
    if (op == 2) return "R7";
    if (op == 0) return (st == 0) ? "R2" : "R4";
    return (st == 2) ? "R4" : "R3";
  endfunction
  function automatic string snoopTag(int st, int cmd);
    if (cmd == 3 || st == 0) return "R8";
    return (st == 2) ? "R5" : "R6";
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // called at the negedge right after the edge that took the event
  task automatic completeProc(input int idx, input int expCmd, input int expFinal,
                              input string tag);
    if (expCmd != 0) begin
      check(busReq == 1'b1, tag, "busReq raised", int'(busReq), 1);
      check(int'(busCmd) == expCmd, tag, "busCmd", int'(busCmd), expCmd);
      check(int'(busIndex) == idx, tag, "busIndex", int'(busIndex), idx);
      check(procDone == 1'b0, "R9", "procDone early", int'(procDone), 0);
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        check(busReq == 1'b1 && int'(busCmd) == expCmd && int'(busIndex) == idx,
              "R9", "request held", int'(busCmd), expCmd);
      end
      busAck = 1'b1;
      @(negedge clk);
      busAck = 1'b0;
    end
    check(procDone == 1'b1, tag, "procDone", int'(procDone), 1);
    check(busReq == 1'b0, (expCmd != 0) ? "R9" : "R4", "busReq low", int'(busReq), 0);
    procValid = 1'b0;
    @(negedge clk);
    check(procDone == 1'b0, "R9", "procDone single pulse", int'(procDone), 0);
    procIndex = IW'(idx);
    check(int'(procState) == expFinal, tag, "final state", int'(procState), expFinal);
    expState[idx] = expFinal;
  endtask

  task automatic doProc(input int idx, input int op);
    int st;
    st = expState[idx];
    @(negedge clk);
    procValid = 1'b1;
    procOp = 2'(op);
    procIndex = IW'(idx);
    @(negedge clk);
    completeProc(idx, mdlBus(st, op), mdlTgt(st, op), procTag(st, op));
  endtask

  task automatic bringTo(input int idx, input int st);
    if (expState[idx] != 0) doProc(idx, 2);
    if (st == 1) doProc(idx, 0);
    if (st == 2) doProc(idx, 1);
  endtask

  task automatic doSnoop(input int idx, input int cmd);
    int st, es;
    string tag;
    st = expState[idx];
    tag = snoopTag(st, cmd);
    es = mdlSupply(st, cmd);
    @(negedge clk);
    snoopValid = 1'b1;
    snoopCmd = 2'(cmd);
    snoopIndex = IW'(idx);
    procIndex = IW'(idx);
    @(negedge clk);
    snoopValid = 1'b0;
    check(int'(supplyData) == es, tag, "supplyData", int'(supplyData), es);
    if (es == 1) check(int'(supplyIndex) == idx, tag, "supplyIndex", int'(supplyIndex), idx);
    check(int'(procState) == mdlSnoop(st, cmd), tag, "state after snoop",
          int'(procState), mdlSnoop(st, cmd));
    expState[idx] = mdlSnoop(st, cmd);
    @(negedge clk);
    check(supplyData == 1'b0, "R5", "supplyData pulse ends", int'(supplyData), 0);
  endtask

  task automatic doBoth(input int idx, input int cmd, input int op);
    int st, eff, es, bc;
    st = expState[idx];
    eff = mdlSnoop(st, cmd);
    es = mdlSupply(st, cmd);
    bc = mdlBus(eff, op);
    @(negedge clk);
    snoopValid = 1'b1;
    snoopCmd = 2'(cmd);
    snoopIndex = IW'(idx);
    procValid = 1'b1;
    procOp = 2'(op);
    procIndex = IW'(idx);
    @(negedge clk);
    snoopValid = 1'b0;
    check(int'(supplyData) == es, "R10", "supplyData on collision", int'(supplyData), es);
    if (bc != 0)
      check(int'(procState) == eff, "R10", "post-snoop state while pending",
            int'(procState), eff);
    completeProc(idx, bc, mdlTgt(eff, op), "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog expired: actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) expState[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busReq == 1'b0 && procDone == 1'b0 && supplyData == 1'b0, "R1",
          "outputs low after reset", int'({busReq, procDone, supplyData}), 0);
    for (int i = 0; i < NL; i++) begin
      procIndex = IW'(i);
      #1;
      check(procState == 2'd0, "R1", "line Invalid after reset", int'(procState), 0);
    end

    // processor events from every starting state
    for (int st = 0; st < 3; st++)
      for (int op = 0; op < 3; op++) begin
        bringTo((st * 3 + op) % NL, st);
        doProc((st * 3 + op) % NL, op);
      end

    // observed transactions against every starting state
    for (int st = 0; st < 3; st++)
      for (int cmd = 1; cmd < 4; cmd++) begin
        bringTo((st * 3 + cmd) % NL, st);
        doSnoop((st * 3 + cmd) % NL, cmd);
      end

    // same line, same cycle: snoop then processor
    for (int st = 0; st < 3; st++)
      for (int cmd = 1; cmd < 4; cmd++)
        for (int op = 0; op < 3; op++) begin
          bringTo((st + cmd + op) % NL, st);
          doBoth((st + cmd + op) % NL, cmd, op);
        end

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule